// File: doc/BRIEF.md
# Watchdog Timer With Keyed Disable

This block is a watchdog built on a 32-bit down counter. Software sets a 32-bit reload value through two 16-bit halves and restarts the counter by writing to a clear register. If software stops servicing the watchdog, the counter reaches zero. The block then raises a one-cycle timeout pulse and starts a new period from the reload value.

All access goes through a small synchronous bus with a 3-bit word address, 16-bit write data, two byte-lane enables, a write strobe, a read strobe and combinational read data. The live count can be read as two 16-bit halves. Reading the high half captures the low half at the same moment, so a high-then-low read pair forms one consistent 32-bit value. The watchdog can only be switched off by writing two key bytes to the disable register, one after the other. It then stays off until reset.

Address map: 0 reload high, 1 reload low, 2 count high (read-only), 3 count low (read-only), 4 clear, 5 disable. Addresses 6 and 7 read as zero and ignore writes.

Top module: `wdg_timer`

## Requirements
- R1: After reset the watchdog is enabled, both reload halves read FFFFh, the counter holds FFFF_FFFFh and `timeout` is low.
- R2: A write to reload high (address 0) or reload low (address 1) updates only the bytes whose lane enable is set: `bus_be[1]` selects bits 15:8 and `bus_be[0]` selects bits 7:0. Both halves read back what was written.
- R3: While enabled, any write to the clear register (address 4) loads the counter with {reload high, reload low}, whatever the data. A clear wins over a timeout in the same cycle.
- R4: While enabled and not cleared, the counter falls by one each clock. When it is zero, the next edge raises `timeout` for exactly one cycle and reloads the counter, so a reload value N gives a timeout every N+1 cycles.
- R5: Writes to count high (address 2) and count low (address 3) change neither the counter nor the reload registers.
- R6: A read of count high returns bits 31:16 of the counter in that cycle and captures bits 15:0. A later read of count low returns the captured bits, not the live count.
- R7: A write of 55h in bits 7:0 (with `bus_be[0]` set) to the disable register (address 5), followed by a write of AAh the same way as the very next bus write, disables the watchdog. From then until reset the counter holds its value, clears are ignored and no timeout occurs.
- R8: The disable sequence is abandoned, and the watchdog stays enabled, when any other bus write follows the 55h or when the second byte is not AAh. Reads between the two writes do not abandon it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of `bus_rd` |
| timeout | output | 1 | One-cycle pulse when the counter expires |

## Verification
The embedded properties assume that `bus_wr` and `bus_rd` are one-cycle strobes and that the address and data stay steady while a strobe is high. They also assume a nonzero reload value wherever the one-cycle pulse width is claimed, because a reload of zero legitimately gives a timeout every cycle. The directed stimulus drives every strobe for exactly one cycle, changing inputs only on the falling edge. It always programs a nonzero reload before it looks at timeout periods. Reload values are kept small, or placed in the high half, so that each expected period or count difference is reached well within the run.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int BYTES  = DATA_W / 8;

    typedef enum logic [ADDR_W-1:0] {
        A_RLD_HI = 3'd0,
        A_RLD_LO = 3'd1,
        A_CNT_HI = 3'd2,
        A_CNT_LO = 3'd3,
        A_CLEAR  = 3'd4,
        A_KILL   = 3'd5
    } wdg_addr_e;

    typedef enum logic [1:0] {
        K_IDLE,
        K_ARMED,
        K_OFF
    } key_state_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        wdg_addr_e         addr;
        logic [BYTES-1:0]  be;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    function automatic logic [DATA_W-1:0] merge_lanes(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [BYTES-1:0]  lanes
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int b = 0; b < BYTES; b++) begin
            if (lanes[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  reload,
    output logic              clr_pulse,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rld_hi, rld_lo, snap_lo;

    assign reload    = {rld_hi, rld_lo};
    assign clr_pulse = req.wr && (req.addr == A_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            rld_hi  <= '1;
            rld_lo  <= '1;
            snap_lo <= '1;
        end else begin
            if (req.wr && req.addr == A_RLD_HI) rld_hi <= merge_lanes(rld_hi, req.data, req.be);
            if (req.wr && req.addr == A_RLD_LO) rld_lo <= merge_lanes(rld_lo, req.data, req.be);
            if (req.rd && req.addr == A_CNT_HI) snap_lo <= cnt[DATA_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (req.rd) begin
            case (req.addr)
                A_RLD_HI: rdata = rld_hi;
                A_RLD_LO: rdata = rld_lo;
                A_CNT_HI: rdata = cnt[CNT_W-1:DATA_W];
                A_CNT_LO: rdata = snap_lo;
                default:  rdata = '0;
            endcase
        end
    end

    // R5: count-register writes leave the reload value untouched
    assert_cnt_write_ro_R5: assert property (@(posedge clk) disable iff (rst)
        (req.wr && (req.addr == A_CNT_HI || req.addr == A_CNT_LO)) |=> $stable(reload));

    // R2: a write with no lanes enabled changes nothing
    assert_no_lane_no_change_R2: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.be == '0) |=> $stable(reload));
endmodule

// File: rtl/wdg_key.sv
module wdg_key
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  wdg_addr_e addr,
    input  logic      lane0,
    input  logic [7:0] byte0,
    output logic      disabled
);
    key_state_e st;
    logic key_wr;

    assign key_wr   = wr && (addr == A_KILL) && lane0;
    assign disabled = (st == K_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= K_IDLE;
        end else if (st != K_OFF && wr) begin
            if (st == K_ARMED && key_wr && byte0 == KEY_SECOND)
                st <= K_OFF;
            else if (key_wr && byte0 == KEY_FIRST)
                st <= K_ARMED;
            else
                st <= K_IDLE;
        end
    end

    // R7: once off, stays off until reset
    assert_off_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (st == K_OFF) |=> (st == K_OFF));

    // R8: an armed checker hit by any other write does not turn off
    assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (st == K_ARMED && wr && !(key_wr && byte0 == KEY_SECOND)) |=> (st != K_OFF));

    // R8: turning off is only possible from the armed state
    assert_off_from_armed_R8: assert property (@(posedge clk) disable iff (rst)
        (st == K_IDLE) |=> (st != K_OFF));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter logic [CNT_W-1:0] RESET_VAL = '1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             timeout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= RESET_VAL;
            timeout <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (en) begin
                if (load) begin
                    cnt <= reload;
                end else if (cnt == '0) begin
                    cnt     <= reload;
                    timeout <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

    // R4: counting down by one while running
    assert_decrement_R4: assert property (@(posedge clk) disable iff (rst)
        (en && !load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R4: timeout only follows a zero count
    assert_timeout_after_zero_R4: assert property (@(posedge clk) disable iff (rst)
        timeout |-> ($past(cnt) == '0));

    // R4: pulse is a single cycle for nonzero reload
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
        (timeout && reload != '0) |=> !timeout);

    // R7: frozen and silent while disabled
    assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(cnt) && !timeout));

    // R3: clear loads the reload value
    assert_clear_load_R3: assert property (@(posedge clk) disable iff (rst)
        (en && load) |=> (cnt == $past(reload)));
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTES-1:0]  bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              timeout
);
    bus_req_t         req;
    logic [CNT_W-1:0] cnt, reload;
    logic             clr_pulse, disabled;

    assign req.wr   = bus_wr;
    assign req.rd   = bus_rd;
    assign req.addr = wdg_addr_e'(bus_addr);
    assign req.be   = bus_be;
    assign req.data = bus_wdata;

    wdg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .cnt       (cnt),
        .reload    (reload),
        .clr_pulse (clr_pulse),
        .rdata     (bus_rdata)
    );

    wdg_key u_key (
        .clk      (clk),
        .rst      (rst),
        .wr       (req.wr),
        .addr     (req.addr),
        .lane0    (req.be[0]),
        .byte0    (req.data[7:0]),
        .disabled (disabled)
    );

    wdg_counter #(.RESET_VAL('1)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en      (!disabled),
        .load    (clr_pulse),
        .reload  (reload),
        .cnt     (cnt),
        .timeout (timeout)
    );

    // R1: no timeout in the cycle after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        rst |=> !timeout);
endmodule

// File: tb/wdg_timer_test.sv
module wdg_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        timeout;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    wdg_timer uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .timeout(timeout)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_to(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!timeout && n < 1000);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        check(timeout == 1'b0, "R1 timeout low", timeout, 0);
        rd(3'd0, v); check(v == 16'hFFFF, "R1 reload hi", v, 16'hFFFF);
        rd(3'd1, v); check(v == 16'hFFFF, "R1 reload lo", v, 16'hFFFF);
        rd(3'd2, v); check(v == 16'hFFFF, "R1 count hi", v, 16'hFFFF);
    endtask

    task automatic t_lanes();
        logic [15:0] v;
        do_reset();
        wr(3'd0, 16'h1234, 2'b10);
        rd(3'd0, v); check(v == 16'h12FF, "R2 hi upper lane", v, 16'h12FF);
        wr(3'd1, 16'hA5C3, 2'b01);
        rd(3'd1, v); check(v == 16'hFFC3, "R2 lo lower lane", v, 16'hFFC3);
        wr(3'd1, 16'h0BEE, 2'b11);
        rd(3'd1, v); check(v == 16'h0BEE, "R2 lo full word", v, 16'h0BEE);
    endtask

    task automatic t_period();
        int n;
        do_reset();
        wr(3'd0, 16'h0000, 2'b11);
        wr(3'd1, 16'h0005, 2'b11);
        wr(3'd4, 16'h0000, 2'b11);
        wait_to(n); check(n == 6, "R4 first period", n, 6);
        wait_to(n); check(n == 6, "R4 reload period", n, 6);
        @(negedge clk); check(timeout == 1'b0, "R4 one-cycle pulse", timeout, 0);
    endtask

    task automatic t_clear();
        int n;
        do_reset();
        wr(3'd0, 16'h0000, 2'b11);
        wr(3'd1, 16'h000A, 2'b11);
        wr(3'd4, 16'h1234, 2'b11);
        repeat (4) @(negedge clk);
        wr(3'd4, 16'h0000, 2'b01);
        wait_to(n); check(n == 11, "R3 clear restarts", n, 11);
    endtask

    task automatic t_readonly();
        logic [15:0] v;
        do_reset();
        wr(3'd0, 16'h0007, 2'b11);
        wr(3'd1, 16'h0000, 2'b11);
        wr(3'd4, 16'h0000, 2'b11);
        wr(3'd2, 16'h0001, 2'b11);
        wr(3'd3, 16'h0000, 2'b11);
        rd(3'd2, v); check(v == 16'h0006, "R5 count hi ignores write", v, 16'h0006);
        rd(3'd0, v); check(v == 16'h0007, "R5 reload hi untouched", v, 16'h0007);
    endtask

    task automatic t_snapshot();
        logic [15:0] v;
        do_reset();
        wr(3'd0, 16'h0001, 2'b11);
        wr(3'd1, 16'h0003, 2'b11);
        wr(3'd4, 16'h0000, 2'b11);
        rd(3'd2, v); check(v == 16'h0001, "R6 count hi live", v, 16'h0001);
        rd(3'd3, v); check(v == 16'h0003, "R6 count lo captured", v, 16'h0003);
    endtask

    task automatic sample_diff(output logic [15:0] d);
        logic [15:0] v, a, b;
        rd(3'd2, v); rd(3'd3, a);
        repeat (10) @(negedge clk);
        rd(3'd2, v); rd(3'd3, b);
        d = a - b;
    endtask

    task automatic setup_1000();
        do_reset();
        wr(3'd0, 16'h0000, 2'b11);
        wr(3'd1, 16'h1000, 2'b11);
        wr(3'd4, 16'h0000, 2'b11);
    endtask

    task automatic t_disable();
        logic [15:0] d;
        int seen;
        setup_1000();
        wr(3'd5, 16'h0055, 2'b01);
        wr(3'd5, 16'h00AA, 2'b01);
        sample_diff(d); check(d == 16'd0, "R7 counter frozen", d, 0);
        wr(3'd4, 16'h0000, 2'b11);
        wr(3'd1, 16'h0000, 2'b11);
        sample_diff(d); check(d == 16'd0, "R7 clear ignored when off", d, 0);
        seen = 0;
        repeat (40) begin @(negedge clk); if (timeout) seen++; end
        check(seen == 0, "R7 no timeout when off", seen, 0);
    endtask

    task automatic t_abort();
        logic [15:0] d, v;
        setup_1000();
        wr(3'd5, 16'h0055, 2'b01);
        wr(3'd1, 16'h1000, 2'b11);
        wr(3'd5, 16'h00AA, 2'b01);
        sample_diff(d); check(d == 16'd12, "R8 intervening write aborts", d, 12);
        wr(3'd5, 16'h0055, 2'b01);
        wr(3'd5, 16'h0012, 2'b01);
        wr(3'd5, 16'h00AA, 2'b01);
        sample_diff(d); check(d == 16'd12, "R8 wrong second byte aborts", d, 12);
        wr(3'd5, 16'h0055, 2'b01);
        rd(3'd0, v);
        wr(3'd5, 16'h00AA, 2'b01);
        sample_diff(d); check(d == 16'd0, "R8 read between keys allowed", d, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_lanes();
        t_period();
        t_clear();
        t_readonly();
        t_snapshot();
        t_disable();
        t_abort();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule